// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a purely combinational integer arithmetic and logic unit. Two operand buses and a carry input are presented together with a 4-bit operation code. The block returns a result word and five status bits in the same cycle. The status bits are carry, overflow, zero, negative and parity, and they are meant to be captured by an external condition-code register. The carry input usually comes from that register, so the unit can chain multi-word additions, subtractions and rotations.

The carry output has a different meaning for each class of operation. After an addition it is the carry out of the top bit. After a subtraction or a negation it flags a borrow. After a shift or rotate it holds the bit that left the operand. The data width is a parameter and defaults to 8 bits.

Top module: `int_alu`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (add with carry) put A+B, plus carry_i for opcode 1, on y_o modulo 2^WIDTH. carry_o is bit WIDTH of the full sum.
- R2: Opcode 2 (subtract) and opcode 3 (subtract with borrow) put A−B, minus carry_i for opcode 3, on y_o modulo 2^WIDTH. carry_o is 1 exactly when the unsigned subtraction needed a borrow.
- R3: For opcodes 0–4, ovf_o is 1 exactly when the true signed (two's complement) result lies outside the range that y_o can hold.
- R4: Opcode 4 (negate) puts 0−A on y_o. carry_o is 1 when A is nonzero.
- R5: Opcode 5 passes A through. Opcodes 6, 7, 8 and 9 give A AND B, A OR B, A XOR B and NOT A. For all five, carry_o and ovf_o are 0.
- R6: Opcode 10 shifts A left by one with a 0 entering bit 0, and carry_o takes the old top bit. Opcode 11 shifts A right by one with a 0 entering the top bit, and carry_o takes the old bit 0.
- R7: Opcode 12 shifts A right by one and keeps the top bit unchanged. carry_o takes the old bit 0.
- R8: Opcode 13 rotates left through carry: carry_i enters bit 0 and the old top bit goes to carry_o. Opcode 14 rotates right through carry: carry_i enters the top bit and the old bit 0 goes to carry_o.
- R9: For opcodes 10–14, ovf_o is 0.
- R10: For opcodes 0–14, zero_o is 1 exactly when y_o is all zeros, and neg_o equals the top bit of y_o.
- R11: For opcodes 0–14, par_o is 1 when y_o holds an odd number of one bits and 0 when the count is even.
- R12: Opcode 15 is unassigned. It drives y_o and all five status bits to 0, whatever the operands and carry_i are.
- R13: carry_i has no effect on any output except under opcodes 1, 3, 13 and 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation code |
| carry_i | input | 1 | Stored carry/borrow from an earlier operation |
| y_o | output | WIDTH | Result word |
| carry_o | output | 1 | Carry, borrow, or bit shifted out |
| ovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Top bit of the result |
| par_o | output | 1 | Odd parity of the result |

## Verification
Every output is due in the same cycle as its inputs, since no register lies between any input and any output. The bench applies each operand set at a falling clock edge. It samples a fixed 2 ns later, after the logic has settled and well before the next rising edge, so no check depends on the order of events at an edge. Expected results come from a signed and unsigned integer model inside the bench. Each check compares that model's result with the outputs, and the requirements covering carry_i and the unassigned opcode are checked by applying both carry_i values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_NEG  = 4'd4,
        OP_PASS = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_NOT  = 4'd9,
        OP_SHL  = 4'd10,
        OP_SHR  = 4'd11,
        OP_SAR  = 4'd12,
        OP_RCL  = 4'd13,
        OP_RCR  = 4'd14,
        OP_RSVD = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_NONE
    } op_class_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic neg;
        logic par;
    } status_t;

    function automatic op_class_e classify(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG:          return CLS_ARITH;
            OP_PASS, OP_AND, OP_OR, OP_XOR, OP_NOT:          return CLS_LOGIC;
            OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR:          return CLS_SHIFT;
            default:                                         return CLS_NONE;
        endcase
    endfunction

    function automatic logic uses_carry_in(alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBB);
    endfunction

    function automatic logic is_subtract(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_NEG);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W:0] ext;
    logic [W:0] cin_ext;

    assign cin_ext = {{W{1'b0}}, cin};

    always_comb begin
        if (sub) begin
            ext = {1'b0, x} - {1'b0, y} - cin_ext;
        end else begin
            ext = {1'b0, x} + {1'b0, y} + cin_ext;
        end
        res  = ext[MSB:0];
        cout = ext[W];
        if (sub) begin
            ovf = (x[MSB] != y[MSB]) && (res[MSB] != x[MSB]);
        end else begin
            ovf = (x[MSB] == y[MSB]) && (res[MSB] != x[MSB]);
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_PASS: res = a;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int MSB = W - 1;

    logic       left;
    logic       fill;

    always_comb begin
        left = (op == OP_SHL) || (op == OP_RCL);
        case (op)
            OP_SAR:         fill = a[MSB];
            OP_RCL, OP_RCR: fill = cin;
            default:        fill = 1'b0;
        endcase
        if (left) begin
            res  = {a[MSB-1:0], fill};
            cout = a[MSB];
        end else begin
            res  = {fill, a[MSB:1]};
            cout = a[0];
        end
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] y_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o,
    output logic             neg_o,
    output logic             par_o
);
    localparam int MSB = WIDTH - 1;

    alu_op_e    op;
    op_class_e  cls;

    logic [WIDTH-1:0] ar_x, ar_y, ar_res, lg_res, sh_res;
    logic             ar_cin, ar_cout, ar_ovf, sh_cout;
    logic [WIDTH-1:0] result;
    status_t          st;

    assign op  = alu_op_e'(op_i);
    assign cls = classify(op);

    always_comb begin
        ar_x   = (op == OP_NEG) ? '0  : a_i;
        ar_y   = (op == OP_NEG) ? a_i : b_i;
        ar_cin = uses_carry_in(op) & carry_i;
    end

    alu_arith #(.W(WIDTH)) u_arith (
        .x    (ar_x),
        .y    (ar_y),
        .cin  (ar_cin),
        .sub  (is_subtract(op)),
        .res  (ar_res),
        .cout (ar_cout),
        .ovf  (ar_ovf)
    );

    alu_logic #(.W(WIDTH)) u_logic (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .res (lg_res)
    );

    alu_shift #(.W(WIDTH)) u_shift (
        .op   (op),
        .a    (a_i),
        .cin  (carry_i),
        .res  (sh_res),
        .cout (sh_cout)
    );

    always_comb begin
        st = '0;
        case (cls)
            CLS_ARITH: begin
                result   = ar_res;
                st.carry = ar_cout;
                st.ovf   = ar_ovf;
            end
            CLS_LOGIC: result = lg_res;
            CLS_SHIFT: begin
                result   = sh_res;
                st.carry = sh_cout;
            end
            default:   result = '0;
        endcase
        if (cls != CLS_NONE) begin
            st.zero = (result == '0);
            st.neg  = result[MSB];
            st.par  = ^result;
        end
    end

    assign y_o     = result;
    assign carry_o = st.carry;
    assign ovf_o   = st.ovf;
    assign zero_o  = st.zero;
    assign neg_o   = st.neg;
    assign par_o   = st.par;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   op_i,
    input logic         carry_i,
    input logic [W-1:0] y_o,
    input logic         carry_o,
    input logic         ovf_o,
    input logic         zero_o,
    input logic         neg_o,
    input logic         par_o
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a_i} + {1'b0, b_i};
        if (op_i == 4'd0) begin
            a_r1_add_sum: assert ({carry_o, y_o} == full)
                else $error("R1 add result mismatch");
        end
        if (op_i == 4'd3) begin
            a_r2_sbb_borrow: assert ({carry_o, y_o} ==
                                     ({1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, carry_i}))
                else $error("R2 borrow mismatch");
        end
        if (op_i >= 4'd5 && op_i <= 4'd9) begin
            a_r5_logic_quiet: assert (!carry_o && !ovf_o)
                else $error("R5 carry/overflow set on logic op");
        end
        if (op_i == 4'd13) begin
            a_r8_rcl_ring: assert (carry_o == a_i[W-1] && y_o[0] == carry_i)
                else $error("R8 rotate left through carry");
        end
        if (op_i == 4'd14) begin
            a_r8_rcr_ring: assert (carry_o == a_i[0] && y_o[W-1] == carry_i)
                else $error("R8 rotate right through carry");
        end
        if (op_i >= 4'd10 && op_i <= 4'd14) begin
            a_r9_shift_no_overflow: assert (!ovf_o)
                else $error("R9 overflow on shift");
        end
        if (op_i != 4'd15) begin
            a_r10_zero_flag: assert (zero_o == (y_o == '0) && neg_o == y_o[W-1])
                else $error("R10 zero/negative flag");
            a_r11_parity: assert ((^{y_o, par_o}) == 1'b0)
                else $error("R11 parity flag");
        end else begin
            a_r12_rsvd_quiet: assert (y_o == '0 && !carry_o && !ovf_o && !zero_o && !neg_o && !par_o)
                else $error("R12 unassigned opcode not quiet");
        end
    end
endmodule

bind int_alu int_alu_chk #(.W(WIDTH)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_i),
    .carry_i (carry_i),
    .y_o     (y_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .zero_o  (zero_o),
    .neg_o   (neg_o),
    .par_o   (par_o)
);

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic [3:0]   op = 4'd0;
    logic         ci = 1'b0;
    logic [W-1:0] y;
    logic         co, ov, zf, nf, pf;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    int_alu #(.WIDTH(W)) u_int_alu (
        .a_i(a), .b_i(b), .op_i(op), .carry_i(ci),
        .y_o(y), .carry_o(co), .ovf_o(ov), .zero_o(zf), .neg_o(nf), .par_o(pf)
    );

    // Integer reference model built from the requirement text.
    task automatic model(input int o, input int ua, input int ub, input int c,
                         output int ey, output int ec, output int ev);
        int sa, sb, r, s;
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        ey = 0; ec = 0; ev = 0;
        case (o)
            0, 1: begin                                   // R1, R3
                r  = ua + ub + ((o == 1) ? c : 0);
                s  = sa + sb + ((o == 1) ? c : 0);
                ey = r % 256; ec = (r > 255) ? 1 : 0;
                ev = (s > 127 || s < -128) ? 1 : 0;
            end
            2, 3: begin                                   // R2, R3
                r  = ua - ub - ((o == 3) ? c : 0);
                s  = sa - sb - ((o == 3) ? c : 0);
                ey = (r + 512) % 256; ec = (r < 0) ? 1 : 0;
                ev = (s > 127 || s < -128) ? 1 : 0;
            end
            4: begin                                      // R4
                ey = (256 - ua) % 256; ec = (ua != 0) ? 1 : 0;
                ev = (-sa > 127) ? 1 : 0;
            end
            5: ey = ua;                                   // R5
            6: ey = ua & ub;
            7: ey = ua | ub;
            8: ey = ua ^ ub;
            9: ey = 255 - ua;
            10: begin ey = (ua * 2) % 256; ec = ua / 128; end          // R6
            11: begin ey = ua / 2; ec = ua % 2; end
            12: begin ey = ua / 2 + (ua & 128); ec = ua % 2; end      // R7
            13: begin ey = (ua * 2) % 256 + c; ec = ua / 128; end    // R8
            14: begin ey = ua / 2 + c * 128; ec = ua % 2; end
            default: ;                                    // R12
        endcase
    endtask

    task automatic apply(input int o, input int ua, input int ub, input int c);
        @(negedge clk);
        op = o[3:0]; a = ua[7:0]; b = ub[7:0]; ci = c[0];
        #2;
    endtask

    task automatic compare(input string tag);
        int ey, ec, ev, ez, en, ep, n1;
        model(int'(op), int'(a), int'(b), int'(ci), ey, ec, ev);
        n1 = 0;
        for (int i = 0; i < W; i++) n1 += (ey >> i) & 1;
        ez = (ey == 0) ? 1 : 0;
        en = (ey >= 128) ? 1 : 0;
        ep = n1 % 2;
        if (op == 4'd15) begin ez = 0; en = 0; ep = 0; end
        checks++;
        if (int'(y) != ey || int'(co) != ec || int'(ov) != ev ||
            int'(zf) != ez || int'(nf) != en || int'(pf) != ep) begin
            fails++;
            $display("FAIL %s op=%0d a=%0d b=%0d ci=%0d: y=%0d c=%0d v=%0d z=%0d n=%0d p=%0d expected y=%0d c=%0d v=%0d z=%0d n=%0d p=%0d",
                     tag, op, a, b, ci, y, co, ov, zf, nf, pf, ey, ec, ev, ez, en, ep);
        end
    endtask

    task automatic run(input string tag, input int o, input int ua, input int ub, input int c);
        apply(o, ua, ub, c);
        compare(tag);
    endtask

    task automatic t_reset_state;
        // after reset the inputs rest at add, 0, 0: expected zero flag set (R10)
        compare("R10 idle");
    endtask

    task automatic t_add;
        run("R1 add", 0, 8'h12, 8'h34, 0);
        run("R1 add carry", 0, 8'hFF, 8'h01, 0);
        run("R3 add overflow", 0, 8'h7F, 8'h01, 0);
        run("R3 add neg overflow", 0, 8'h80, 8'h80, 0);
        run("R1 adc", 1, 8'hFE, 8'h01, 1);
        run("R1 adc wrap", 1, 8'hFF, 8'hFF, 1);
    endtask

    task automatic t_sub;
        run("R2 sub", 2, 8'h50, 8'h20, 0);
        run("R2 sub borrow", 2, 8'h00, 8'h01, 0);
        run("R3 sub overflow", 2, 8'h80, 8'h01, 0);
        run("R2 sbb", 3, 8'h10, 8'h0F, 1);
        run("R2 sbb borrow all", 3, 8'h00, 8'h00, 1);
        run("R3 sbb overflow", 3, 8'h7F, 8'hFF, 1);
    endtask

    task automatic t_neg;
        run("R4 neg zero", 4, 8'h00, 0, 0);
        run("R4 neg one", 4, 8'h01, 0, 0);
        run("R4 neg min", 4, 8'h80, 0, 0);
    endtask

    task automatic t_logic;
        for (int o = 5; o <= 9; o++) begin
            run("R5 logic", o, 8'hA5, 8'h3C, 1);
            run("R5 logic", o, 8'hFF, 8'h00, 0);
        end
    endtask

    task automatic t_shift;
        run("R6 shl", 10, 8'h81, 0, 1);
        run("R6 shr", 11, 8'h81, 0, 1);
        run("R7 sar neg", 12, 8'h81, 0, 0);
        run("R7 sar pos", 12, 8'h42, 0, 1);
        run("R9 shl sign change", 10, 8'h40, 0, 0);
    endtask

    task automatic t_rotate;
        run("R8 rcl", 13, 8'h80, 0, 0);
        run("R8 rcl cin", 13, 8'h00, 0, 1);
        run("R8 rcr", 14, 8'h01, 0, 0);
        run("R8 rcr cin", 14, 8'h00, 0, 1);
        run("R11 parity", 14, 8'h07, 0, 1);
    endtask

    task automatic t_reserved;
        run("R12 rsvd", 15, 8'hFF, 8'hFF, 1);
        run("R12 rsvd zero", 15, 8'h00, 8'h00, 0);
    endtask

    task automatic t_carry_ignored;
        // R13: same operands with both carry_i values, each result against the model
        for (int o = 0; o < 16; o++) begin
            run("R13 ci=0", o, 8'hC3, 8'h5A, 0);
            run("R13 ci=1", o, 8'hC3, 8'h5A, 1);
        end
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            run("R1-model random", int'($urandom_range(15, 0)), int'($urandom_range(255, 0)),
                int'($urandom_range(255, 0)), int'($urandom_range(1, 0)));
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        t_reset_state();
        t_add();
        t_sub();
        t_neg();
        t_logic();
        t_shift();
        t_rotate();
        t_reserved();
        t_carry_ignored();
        t_random();
        finish_run();
    end
endmodule